// File: doc/BRIEF.md
# Dual-Channel Result Supervisor with Power-On Pattern Test

This block watches over two identical controller channels that run side by side and back each other up: one healthy channel is enough to reach a safe reaction. After reset it first runs a pattern test. It offers a stored stimulus word on its test port and waits until both channels have returned a result. It then checks both results against a stored expected word and moves on to the next pattern. Only when every pattern has passed does it switch to normal operation. In normal operation it compares the two channel result streams on every clock cycle.

In normal operation, when the channels agree, the actuator output carries channel A's value, registered once. Any disagreement latches a safe phase. The same happens on a failed test pattern. In the safe phase the interrupt is high and the actuator output is forced off. Only reset leaves the safe phase.

Flow control: the result buses have no ready signal. The supervisor takes a result in every cycle in which its valid is high, so it never stalls a channel. The test port has no ready signal either. `tp_valid` and `tp_data` stay constant until both channels have delivered a result for the current pattern, and this hold is the channels' only flow control.

Top module: `dual_cmp_guard`

## Requirements
- R1: After reset the block is in the pattern-test phase with `act_on`=0, `act_data`=0, `irq`=0, `tp_valid`=1 and `tp_data` equal to pattern 0.
- R2: While the pattern test runs, `act_on` is 0 and `act_data` is 0.
- R3: Pattern i stays on `tp_data` with `tp_valid` high until a result has arrived from both channels. The two results may come in the same cycle or in different cycles, in either order; a channel's first result for a pattern is kept. The block then moves to pattern i+1.
- R4: If either channel's result for a pattern differs from that pattern's expected word, then from the next cycle `irq`=1, `act_on`=0, `act_data`=0 and `tp_valid`=0.
- R5: When the last pattern passes, from the next cycle `tp_valid`=0 and `act_on`=1.
- R6: In normal operation, a cycle in which both valids are high and `a_data`==`b_data` sets `act_data` to that value from the next cycle.
- R7: In normal operation, a cycle in which both valids are high and the data differ sets `irq`=1, `act_on`=0 and `act_data`=0 from the next cycle.
- R8: In normal operation, a cycle in which exactly one valid is high is a fault with the same effect as R7.
- R9: In normal operation, a cycle with neither valid high leaves `act_data` unchanged.
- R10: The safe phase is held until reset. Later channel activity, matching or not, changes none of `irq`, `act_on` or `act_data`.
- R11: The default setup has DW=12 and four patterns. Pattern i = (0x0A5 + i*0x111) mod 2^12, giving 0x0A5, 0x1B6, 0x2C7 and 0x3D8. The expected result for each pattern is its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Channel A result strobe |
| a_data | input | DW | Channel A result |
| b_valid | input | 1 | Channel B result strobe |
| b_data | input | DW | Channel B result |
| tp_valid | output | 1 | Test stimulus present |
| tp_data | output | DW | Test stimulus word |
| act_on | output | 1 | Actuator output enabled |
| act_data | output | DW | Gated actuator value |
| irq | output | 1 | Fault interrupt, latched |

## Verification
The bench delivers the two test results in separate cycles and in both orders. A design that only checks results arriving in the same cycle would then hang or advance on half the data. It corrupts a single channel on the third pattern, which catches a design that checks only channel A or only the first pattern. In normal operation it raises one valid on its own, which an equality-only comparator would miss. After a fault it feeds matching data again to show the safe phase is not left. An idle cycle checks that the actuator value is held rather than cleared or overwritten with stale data.

// File: rtl/dual_cmp_pkg.sv
package dual_cmp_pkg;

  typedef enum logic [1:0] {
    PH_SELFTEST = 2'd0,
    PH_RUN      = 2'd1,
    PH_SAFE     = 2'd2
  } phase_t;

  // Stimulus word number idx of the power-on test, before width trimming
  function automatic logic [31:0] pat_word(input logic [31:0] seed,
                                           input logic [31:0] step,
                                           input int unsigned idx);
    return seed + step * 32'(idx);
  endfunction

endpackage

// File: rtl/dcmp_selftest.sv
module dcmp_selftest #(
  parameter int          DW       = 12,
  parameter int          N_PAT    = 4,
  parameter logic [31:0] PAT_SEED = 32'h0A5,
  parameter logic [31:0] PAT_STEP = 32'h111,
  parameter logic [31:0] EXP_MASK = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          tp_valid,
  output logic [DW-1:0] tp_data,
  output logic          st_pass,
  output logic          st_fail
);
  import dual_cmp_pkg::*;

  localparam int IW = (N_PAT > 1) ? $clog2(N_PAT) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_PAT - 1);

  logic [DW-1:0] pat_tab [N_PAT];
  logic [DW-1:0] exp_tab [N_PAT];

  for (genvar g = 0; g < N_PAT; g++) begin : g_tab
    localparam logic [31:0] PW = pat_word(PAT_SEED, PAT_STEP, g);
    localparam logic [31:0] EW = PW ^ EXP_MASK;
    assign pat_tab[g] = PW[DW-1:0];
    assign exp_tab[g] = EW[DW-1:0];
  end

  logic [IW-1:0] idx;
  logic          a_got, b_got;
  logic [DW-1:0] a_hold, b_hold;

  logic          a_have, b_have, check, ok;
  logic [DW-1:0] a_res, b_res;

  always_comb begin
    a_have = a_got | a_valid;
    b_have = b_got | b_valid;
    a_res  = a_got ? a_hold : a_data;
    b_res  = b_got ? b_hold : b_data;
    check  = en && a_have && b_have;
    ok     = (a_res == exp_tab[idx]) && (b_res == exp_tab[idx]);
  end

  assign st_fail  = check && !ok;
  assign st_pass  = check && ok && (idx == LAST);
  assign tp_valid = en;
  assign tp_data  = en ? pat_tab[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      a_got  <= 1'b0;
      b_got  <= 1'b0;
      a_hold <= '0;
      b_hold <= '0;
    end else if (!en) begin
      a_got <= 1'b0;
      b_got <= 1'b0;
    end else if (check) begin
      a_got <= 1'b0;
      b_got <= 1'b0;
      if (ok && idx != LAST) idx <= idx + 1'b1;
    end else begin
      if (a_valid && !a_got) begin
        a_got  <= 1'b1;
        a_hold <= a_data;
      end
      if (b_valid && !b_got) begin
        b_got  <= 1'b1;
        b_hold <= b_data;
      end
    end
  end

  // R3: the stimulus word only changes once a pattern has been checked
  assert_hold_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !check) |=> (!tp_valid || tp_data == $past(tp_data)));

  // R3: a pattern never passes and fails at once
  assert_pass_fail_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_pass && st_fail));

endmodule

// File: rtl/dcmp_xcheck.sv
module dcmp_xcheck #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          fault,
  output logic [DW-1:0] hold_data
);

  logic both, lone, differ;

  always_comb begin
    both   = a_valid && b_valid;
    lone   = a_valid ^ b_valid;
    differ = both && (a_data != b_data);
    fault  = en && (lone || differ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_data <= '0;
    else if (fault)        hold_data <= '0;
    else if (en && both)   hold_data <= a_data;
  end

  // R6: agreeing results are carried to the hold register
  assert_update_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && a_valid && b_valid && a_data == b_data) |=> hold_data == $past(a_data));

  // R9: idle cycles keep the value
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid && !b_valid) |=> $stable(hold_data));

endmodule

// File: rtl/dcmp_phase.sv
module dcmp_phase (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_pass,
  input  logic                  st_fail,
  input  logic                  run_fault,
  output dual_cmp_pkg::phase_t  phase
);
  import dual_cmp_pkg::*;

  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_SELFTEST: if (st_fail) nxt = PH_SAFE;
                   else if (st_pass) nxt = PH_RUN;
      PH_RUN:      if (run_fault) nxt = PH_SAFE;
      PH_SAFE:     nxt = PH_SAFE;
      default:     nxt = PH_SAFE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_SELFTEST;
    else        phase <= nxt;
  end

  // R10: the safe phase is never left without reset
  assert_safe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAFE) |=> (phase == PH_SAFE));

endmodule

// File: rtl/dual_cmp_guard.sv
module dual_cmp_guard #(
  parameter int          DW       = 12,
  parameter int          N_PAT    = 4,
  parameter logic [31:0] PAT_SEED = 32'h0A5,
  parameter logic [31:0] PAT_STEP = 32'h111,
  parameter logic [31:0] EXP_MASK = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          tp_valid,
  output logic [DW-1:0] tp_data,
  output logic          act_on,
  output logic [DW-1:0] act_data,
  output logic          irq
);
  import dual_cmp_pkg::*;

  phase_t        phase;
  logic          st_pass, st_fail, run_fault;
  logic [DW-1:0] hold_data;

  dcmp_selftest #(
    .DW(DW), .N_PAT(N_PAT), .PAT_SEED(PAT_SEED),
    .PAT_STEP(PAT_STEP), .EXP_MASK(EXP_MASK)
  ) u_selftest (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_SELFTEST),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .tp_valid(tp_valid), .tp_data(tp_data),
    .st_pass(st_pass), .st_fail(st_fail)
  );

  dcmp_xcheck #(.DW(DW)) u_xcheck (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .fault(run_fault), .hold_data(hold_data)
  );

  dcmp_phase u_phase (
    .clk(clk), .rst_n(rst_n),
    .st_pass(st_pass), .st_fail(st_fail), .run_fault(run_fault),
    .phase(phase)
  );

  assign act_on   = (phase == PH_RUN);
  assign act_data = act_on ? hold_data : '0;
  assign irq      = (phase == PH_SAFE);

  // R2: no actuator drive while stimulus is offered
  assert_off_in_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tp_valid |-> (!act_on && act_data == '0));

  // R4: a failed pattern leads to the safe phase
  assert_test_fail_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_fail |=> (irq && !act_on && !tp_valid));

  // R5: the last passing pattern opens normal operation
  assert_test_pass_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_pass |=> (act_on && !tp_valid));

  // R7: the interrupt always comes with the output switched off
  assert_irq_gates_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!act_on && act_data == '0));

  // R8: a lone strobe in normal operation trips the interrupt
  assert_lone_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on && (a_valid ^ b_valid)) |=> irq);

  // R10: the interrupt stays raised
  assert_irq_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);

endmodule

// File: tb/dual_cmp_guard_bench.sv
module dual_cmp_guard_bench;
  localparam int DW = 12;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          tp_valid, act_on, irq;
  logic [DW-1:0] tp_data, act_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_cmp_guard u_dual_cmp_guard (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .tp_valid(tp_valid), .tp_data(tp_data),
    .act_on(act_on), .act_data(act_data), .irq(irq)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(12'h0A5 + 12'(i) * 12'h111);
  endfunction

  function automatic logic [DW-1:0] expv(input int i);
    return ~pat(i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Feed all patterns correctly, both results in the same cycle
  task automatic pass_selftest();
    for (int i = 0; i < NP; i++) begin
      a_valid = 1'b1; a_data = expv(i);
      b_valid = 1'b1; b_data = expv(i);
      @(negedge clk);
    end
    idle();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 act_on", act_on, 0);
    chk("R1 act_data", act_data, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tp_valid", tp_valid, 1);
    chk("R1 tp_data", tp_data, pat(0));
    repeat (3) @(negedge clk);
    chk("R2 act_on idle test", act_on, 0);
    chk("R2 tp_data held", tp_data, pat(0));
  endtask

  task automatic t_selftest_split();
    do_reset();
    for (int i = 0; i < NP; i++) begin
      chk("R11 pattern word", tp_data, pat(i));
      if (i % 2 == 0) begin a_valid = 1'b1; a_data = expv(i); end
      else            begin b_valid = 1'b1; b_data = expv(i); end
      @(negedge clk);
      idle();
      chk("R3 held after one result", tp_data, pat(i));
      chk("R2 off during test", act_on, 0);
      // a second result from the same channel is ignored
      if (i % 2 == 0) begin a_valid = 1'b1; a_data = 12'h000; end
      else            begin b_valid = 1'b1; b_data = 12'h000; end
      @(negedge clk);
      idle();
      chk("R3 first result kept", irq, 0);
      if (i % 2 == 0) begin b_valid = 1'b1; b_data = expv(i); end
      else            begin a_valid = 1'b1; a_data = expv(i); end
      @(negedge clk);
      idle();
    end
    chk("R5 act_on", act_on, 1);
    chk("R5 tp_valid", tp_valid, 0);
    chk("R5 irq", irq, 0);
  endtask

  task automatic t_selftest_fail();
    do_reset();
    for (int i = 0; i < 2; i++) begin
      a_valid = 1'b1; a_data = expv(i);
      b_valid = 1'b1; b_data = expv(i);
      @(negedge clk);
    end
    a_valid = 1'b1; a_data = expv(2);
    b_valid = 1'b1; b_data = expv(2) ^ 12'h010;
    @(negedge clk);
    idle();
    chk("R4 irq", irq, 1);
    chk("R4 act_on", act_on, 0);
    chk("R4 tp_valid", tp_valid, 0);
    chk("R4 act_data", act_data, 0);
  endtask

  task automatic t_run_match_idle();
    do_reset();
    pass_selftest();
    a_valid = 1'b1; b_valid = 1'b1; a_data = 12'h5A3; b_data = 12'h5A3;
    @(negedge clk);
    chk("R6 act_data", act_data, 12'h5A3);
    chk("R6 act_on", act_on, 1);
    a_data = 12'hFFF; b_data = 12'hFFF;
    @(negedge clk);
    chk("R6 act_data second", act_data, 12'hFFF);
    idle(); a_data = 12'h123; b_data = 12'h456;
    repeat (2) @(negedge clk);
    chk("R9 hold on idle", act_data, 12'hFFF);
    chk("R9 no fault idle", irq, 0);
  endtask

  task automatic t_run_mismatch();
    do_reset();
    pass_selftest();
    a_valid = 1'b1; b_valid = 1'b1; a_data = 12'h0F0; b_data = 12'h0F0;
    @(negedge clk);
    b_data = 12'h0F1;
    @(negedge clk);
    chk("R7 irq", irq, 1);
    chk("R7 act_on", act_on, 0);
    chk("R7 act_data", act_data, 0);
    a_data = 12'h777; b_data = 12'h777;
    repeat (3) @(negedge clk);
    idle();
    chk("R10 irq stays", irq, 1);
    chk("R10 act_on stays off", act_on, 0);
    chk("R10 act_data stays 0", act_data, 0);
  endtask

  task automatic t_single_valid();
    do_reset();
    pass_selftest();
    a_valid = 1'b1; a_data = 12'h321;
    @(negedge clk);
    idle();
    chk("R8 lone A irq", irq, 1);
    chk("R8 lone A act_on", act_on, 0);
    do_reset();
    pass_selftest();
    b_valid = 1'b1; b_data = 12'h321;
    @(negedge clk);
    idle();
    chk("R8 lone B irq", irq, 1);
  endtask

  initial begin
    t_reset_state();
    t_selftest_split();
    t_selftest_fail();
    t_run_match_idle();
    t_run_mismatch();
    t_single_valid();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule